// File: doc/BRIEF.md
# Peripheral Pin Remap Crossbar

This block connects on-chip peripherals to a set of remappable physical pins. Register contents decide the routing. Each functional input of a peripheral has its own selector, which names the remappable pin that feeds it. Each implemented remappable pin has its own selector, which names the peripheral output that drives it. The selectors are plain inputs here: the registers that hold them, and any write protection around those registers, sit outside the block. The routing from selectors and data to the outputs is purely combinational.

The input selector is five bits wide and covers a 32-slot pin space. Only the first `IMPL_PINS` slots exist as real pins. The package variants use 26 or 16. When an input selector names a slot with no pin behind it, the peripheral input sees a constant idle level, set per input by parameter.

On the output side, code 0 means "no peripheral". The pin's drive enable then drops, and the pin falls back to general-purpose control. Codes 1 through `N_FOUT` pick `per_out[code-1]`. Codes above that count are treated like 0.

Fan-out works in both directions. One pin may feed several peripheral inputs, and one peripheral output may drive several pins. Each destination has exactly one selector, so no destination can ever have two drivers.

Top module: `pps_crossbar`

## Requirements
- R1: When `in_sel` slice f holds a value s below `IMPL_PINS`, `per_in[f]` equals `pin_in[s]`. Slice f is bits [5f+4:5f].
- R2: When `in_sel` slice f holds a value from `IMPL_PINS` up to 31, `per_in[f]` equals `IDLE_LVL[f]` and ignores every bit of `pin_in`.
- R3: Several peripheral inputs may select the same pin at the same time, and each of them follows that pin.
- R4: When `out_sel` slice p holds a code k with 1 ≤ k ≤ `N_FOUT`, `pin_oe[p]` is 1 and `pin_out[p]` equals `per_out[k-1]`. Slice p is bits [5p+4:5p].
- R5: When `out_sel` slice p holds code 0, `pin_oe[p]` is 0 and `pin_out[p]` is 0, whatever `per_out` holds.
- R6: When `out_sel` slice p holds a code above `N_FOUT`, `pin_oe[p]` is 0 and `pin_out[p]` is 0.
- R7: Several pins may select the same peripheral output at the same time, and each of them carries its value.
- R8: Every output follows a change of a selector or a data input without waiting for a clock edge.
- R9: Changing one input selector or one pin selector changes no other destination's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_in | input | IMPL_PINS | Levels sampled from the implemented remappable pins |
| per_out | input | N_FOUT | Functional outputs of the peripherals; bit k-1 is output code k |
| in_sel | input | N_FIN*5 | Per-input pin selectors, 5 bits per peripheral input |
| out_sel | input | IMPL_PINS*OUT_CODE_W | Per-pin output code selectors |
| per_in | output | N_FIN | Routed functional inputs to the peripherals |
| pin_out | output | IMPL_PINS | Level driven on each remappable pin |
| pin_oe | output | IMPL_PINS | Drive enable of each remappable pin; 0 returns the pin to general-purpose control |

## Verification
The bench aims at the slot boundary: selector 25 must route a real pin, while 26 and 31 must give the idle level. An off-by-one decode would leak a pin or a stray bit, and it would show the wrong level on inputs whose idle level is 0. On the output side it tries code `N_FOUT`, code `N_FOUT`+1 and code 0. A design that indexed without subtracting one, or that left invalid codes enabled, would drive the wrong peripheral onto a pin, or drive a pin that should have been released. Fan-out in both directions and isolation between selectors are exercised with toggling data. A design that shared decode state between lanes, or that registered the path, would show stale or crossed values.

// File: rtl/pps_pkg.sv
package pps_pkg;

    // Size of the address space the pin selectors can name.
    localparam int SLOT_SPACE = 32;
    localparam int SLOT_SEL_W = $clog2(SLOT_SPACE);

    typedef logic [SLOT_SEL_W-1:0] slot_sel_t;

    // Drive request for one remappable pad.
    typedef struct packed {
        logic en;
        logic lvl;
    } pad_drive_t;

    localparam pad_drive_t PAD_RELEASED = '{en: 1'b0, lvl: 1'b0};

    // An output code is live when it names an existing peripheral output.
    function automatic logic code_is_live(input int code, input int n_src);
        return (code != 0) && (code <= n_src);
    endfunction

endpackage

// File: rtl/pps_in_lane.sv
module pps_in_lane
    import pps_pkg::*;
#(
    parameter int   IMPL_PINS = 26,
    parameter logic IDLE      = 1'b1
) (
    input  logic [IMPL_PINS-1:0] pin_in,
    input  slot_sel_t            sel,
    output logic                 fin
);

    // Fill the full slot space: real pins first, idle level above them.
    logic [SLOT_SPACE-1:0] slot_lvl;

    for (genvar i = 0; i < SLOT_SPACE; i++) begin : g_slot
        if (i < IMPL_PINS) begin : g_real
            assign slot_lvl[i] = pin_in[i];
        end else begin : g_absent
            assign slot_lvl[i] = IDLE;
        end
    end

    assign fin = slot_lvl[sel];

endmodule

// File: rtl/pps_out_lane.sv
module pps_out_lane
    import pps_pkg::*;
#(
    parameter int N_SRC  = 18,
    parameter int CODE_W = 5
) (
    input  logic [N_SRC-1:0]  per_out,
    input  logic [CODE_W-1:0] code,
    output pad_drive_t        drv
);

    localparam int N_CODES = 2 ** CODE_W;

    // Code-indexed view of the sources; code 0 and codes past N_SRC read 0.
    logic [N_CODES-1:0] by_code;

    for (genvar k = 0; k < N_CODES; k++) begin : g_code
        if (k >= 1 && k <= N_SRC) begin : g_src
            assign by_code[k] = per_out[k-1];
        end else begin : g_none
            assign by_code[k] = 1'b0;
        end
    end

    logic live;

    always_comb begin
        live = code_is_live(int'(code), N_SRC);
        drv  = PAD_RELEASED;
        if (live) begin
            drv.en  = 1'b1;
            drv.lvl = by_code[code];
        end
    end

endmodule

// File: rtl/pps_crossbar.sv
module pps_crossbar
    import pps_pkg::*;
#(
    parameter int               IMPL_PINS  = 26,
    parameter int               N_FIN      = 8,
    parameter int               N_FOUT     = 18,
    parameter int               OUT_CODE_W = 5,
    parameter logic [N_FIN-1:0] IDLE_LVL   = '1
) (
    input  logic [IMPL_PINS-1:0]            pin_in,
    input  logic [N_FOUT-1:0]               per_out,
    input  logic [N_FIN*SLOT_SEL_W-1:0]     in_sel,
    input  logic [IMPL_PINS*OUT_CODE_W-1:0] out_sel,
    output logic [N_FIN-1:0]                per_in,
    output logic [IMPL_PINS-1:0]            pin_out,
    output logic [IMPL_PINS-1:0]            pin_oe
);

    // Input side: one lane per peripheral input, each with its own selector.
    for (genvar f = 0; f < N_FIN; f++) begin : g_fin
        pps_in_lane #(
            .IMPL_PINS (IMPL_PINS),
            .IDLE      (IDLE_LVL[f])
        ) u_lane (
            .pin_in (pin_in),
            .sel    (in_sel[f*SLOT_SEL_W +: SLOT_SEL_W]),
            .fin    (per_in[f])
        );
    end

    // Output side: one lane per implemented pin; a lane has a single source.
    for (genvar p = 0; p < IMPL_PINS; p++) begin : g_pin
        pad_drive_t drv;

        pps_out_lane #(
            .N_SRC  (N_FOUT),
            .CODE_W (OUT_CODE_W)
        ) u_lane (
            .per_out (per_out),
            .code    (out_sel[p*OUT_CODE_W +: OUT_CODE_W]),
            .drv     (drv)
        );

        assign pin_out[p] = drv.lvl;
        assign pin_oe[p]  = drv.en;
    end

endmodule

// File: rtl/pps_crossbar_chk.sv
module pps_crossbar_chk
    import pps_pkg::*;
#(
    parameter int               IMPL_PINS  = 26,
    parameter int               N_FIN      = 8,
    parameter int               N_FOUT     = 18,
    parameter int               OUT_CODE_W = 5,
    parameter logic [N_FIN-1:0] IDLE_LVL   = '1
) (
    input logic [IMPL_PINS-1:0]            pin_in,
    input logic [N_FOUT-1:0]               per_out,
    input logic [N_FIN*SLOT_SEL_W-1:0]     in_sel,
    input logic [IMPL_PINS*OUT_CODE_W-1:0] out_sel,
    input logic [N_FIN-1:0]                per_in,
    input logic [IMPL_PINS-1:0]            pin_out,
    input logic [IMPL_PINS-1:0]            pin_oe
);

    always_comb begin
        for (int f = 0; f < N_FIN; f++) begin
            automatic int s = int'(in_sel[f*SLOT_SEL_W +: SLOT_SEL_W]);
            if (s < IMPL_PINS) begin
                a_r1_in_route: assert (per_in[f] == pin_in[s]);
            end else begin
                a_r2_idle_slot: assert (per_in[f] == IDLE_LVL[f]);
            end
        end
        for (int p = 0; p < IMPL_PINS; p++) begin
            automatic int c = int'(out_sel[p*OUT_CODE_W +: OUT_CODE_W]);
            if (c >= 1 && c <= N_FOUT) begin
                a_r4_out_route: assert (pin_oe[p] && pin_out[p] == per_out[c-1]);
            end else if (c == 0) begin
                a_r5_code_zero: assert (!pin_oe[p] && !pin_out[p]);
            end else begin
                a_r6_code_invalid: assert (!pin_oe[p] && !pin_out[p]);
            end
        end
    end

endmodule

bind pps_crossbar pps_crossbar_chk #(
    .IMPL_PINS  (IMPL_PINS),
    .N_FIN      (N_FIN),
    .N_FOUT     (N_FOUT),
    .OUT_CODE_W (OUT_CODE_W),
    .IDLE_LVL   (IDLE_LVL)
) u_chk (
    .pin_in  (pin_in),
    .per_out (per_out),
    .in_sel  (in_sel),
    .out_sel (out_sel),
    .per_in  (per_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/pps_crossbar_bench.sv
`timescale 1ns/1ps
module pps_crossbar_bench;

    localparam int         IMPL   = 26;
    localparam int         NFI    = 8;
    localparam int         NFO    = 18;
    localparam int         CW     = 5;
    localparam logic [7:0] IDLE   = 8'hF0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [IMPL-1:0]          pin_in  = '0;
    logic [NFO-1:0]           per_out = '0;
    logic [NFI-1:0][4:0]      isel    = '0;
    logic [IMPL-1:0][CW-1:0]  osel    = '0;
    logic [NFI-1:0]           per_in;
    logic [IMPL-1:0]          pin_out;
    logic [IMPL-1:0]          pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pps_crossbar #(
        .IMPL_PINS  (IMPL),
        .N_FIN      (NFI),
        .N_FOUT     (NFO),
        .OUT_CODE_W (CW),
        .IDLE_LVL   (IDLE)
    ) u_pps_crossbar (
        .pin_in  (pin_in),
        .per_out (per_out),
        .in_sel  (isel),
        .out_sel (osel),
        .per_in  (per_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected outputs derived from the requirement text.
    function automatic logic [NFI-1:0] want_in();
        logic [NFI-1:0] v;
        for (int f = 0; f < NFI; f++)
            v[f] = (int'(isel[f]) < IMPL) ? pin_in[isel[f]] : IDLE[f];
        return v;
    endfunction

    function automatic logic [IMPL-1:0] want_oe();
        logic [IMPL-1:0] v;
        for (int p = 0; p < IMPL; p++)
            v[p] = (osel[p] != 0) && (int'(osel[p]) <= NFO);
        return v;
    endfunction

    function automatic logic [IMPL-1:0] want_out();
        logic [IMPL-1:0] v;
        for (int p = 0; p < IMPL; p++)
            v[p] = ((osel[p] != 0) && (int'(osel[p]) <= NFO)) ? per_out[osel[p]-1] : 1'b0;
        return v;
    endfunction

    task automatic settle();
        @(posedge clk);
        #3;
    endtask

    task automatic t_reset_state();
        isel = '0; osel = '0; pin_in = 26'h2AA_AAAA; per_out = '1;
        settle();
        chk("R5 all pins released", 32'(pin_oe), 32'h0);
        chk("R5 all pin levels low", 32'(pin_out), 32'h0);
        chk("R1 sel 0 reads pin 0", 32'(per_in), 32'h00);
    endtask

    task automatic t_in_route();
        for (int n = 0; n < 4; n++) begin
            pin_in = 26'h15A_5C3E ^ (26'h3_1F07 << n);
            for (int f = 0; f < NFI; f++) isel[f] = 5'((f * 3 + n * 5) % IMPL);
            settle();
            chk("R1 input routing", 32'(per_in), 32'(want_in()));
        end
        isel[0] = 5'd25; pin_in = '0; pin_in[25] = 1'b1;
        settle();
        chk("R1 top real slot 25", 32'(per_in[0]), 32'h1);
    endtask

    task automatic t_in_absent();
        isel[0] = 5'd26; isel[1] = 5'd31; isel[4] = 5'd26; isel[7] = 5'd31;
        pin_in = '1;
        settle();
        chk("R2 idle in0 slot26", 32'(per_in[0]), 32'h0);
        chk("R2 idle in1 slot31", 32'(per_in[1]), 32'h0);
        chk("R2 idle in4 slot26", 32'(per_in[4]), 32'h1);
        pin_in = '0;
        settle();
        chk("R2 idle in7 slot31", 32'(per_in[7]), 32'h1);
        chk("R2 in0 ignores pins", 32'(per_in[0]), 32'h0);
    endtask

    task automatic t_in_fanout();
        for (int f = 0; f < NFI; f++) isel[f] = 5'd7;
        pin_in = '0; pin_in[7] = 1'b1;
        settle();
        chk("R3 fanout high", 32'(per_in), 32'hFF);
        pin_in[7] = 1'b0; pin_in[6] = 1'b1; pin_in[8] = 1'b1;
        settle();
        chk("R3 fanout low", 32'(per_in), 32'h00);
    endtask

    task automatic t_out_route();
        for (int n = 0; n < 3; n++) begin
            per_out = 18'h2_D3A5 ^ (18'h1_0F0F >> n);
            for (int p = 0; p < IMPL; p++) osel[p] = 5'(1 + (p + n * 7) % NFO);
            settle();
            chk("R4 pin enables", 32'(pin_oe), 32'(want_oe()));
            chk("R4 pin levels", 32'(pin_out), 32'(want_out()));
        end
        osel[3] = 5'd18; per_out = '0; per_out[17] = 1'b1;
        settle();
        chk("R4 last code level", 32'(pin_out[3]), 32'h1);
        osel[4] = 5'd1; per_out[0] = 1'b1;
        settle();
        chk("R4 code 1 level", 32'(pin_out[4]), 32'h1);
    endtask

    task automatic t_out_release();
        per_out = '1;
        osel[0] = 5'd0; osel[1] = 5'd19; osel[2] = 5'd31;
        settle();
        chk("R5 code 0 oe", 32'(pin_oe[0]), 32'h0);
        chk("R5 code 0 level", 32'(pin_out[0]), 32'h0);
        chk("R6 code 19 oe", 32'(pin_oe[1]), 32'h0);
        chk("R6 code 31 level", 32'(pin_out[2]), 32'h0);
    endtask

    task automatic t_out_fanout();
        osel = '0;
        osel[0] = 5'd5; osel[12] = 5'd5; osel[25] = 5'd5;
        per_out = '0; per_out[4] = 1'b1;
        settle();
        chk("R7 fanout levels", 32'(pin_out), 32'h200_1001);
        chk("R7 fanout enables", 32'(pin_oe), 32'h200_1001);
        per_out[4] = 1'b0;
        settle();
        chk("R7 fanout follows", 32'(pin_out), 32'h0);
    endtask

    task automatic t_comb_path();
        @(posedge clk);
        #2;
        isel[2] = 5'd9; pin_in = '0; pin_in[9] = 1'b1; osel[6] = 5'd2; per_out = 18'h2;
        #1;
        chk("R8 input path no edge", 32'(per_in[2]), 32'h1);
        chk("R8 output path no edge", 32'({pin_oe[6], pin_out[6]}), 32'h3);
        pin_in[9] = 1'b0; per_out = '0;
        #1;
        chk("R8 data change no edge", 32'({per_in[2], pin_out[6]}), 32'h0);
    endtask

    task automatic t_isolation();
        logic [NFI-1:0]  in_before;
        logic [IMPL-1:0] out_before, oe_before;
        pin_in = 26'h33C_C3A5; per_out = 18'h2_5A5A;
        for (int f = 0; f < NFI; f++) isel[f] = 5'(f * 2);
        for (int p = 0; p < IMPL; p++) osel[p] = 5'(p % 20);
        settle();
        in_before = per_in; out_before = pin_out; oe_before = pin_oe;
        isel[3] = 5'd1;
        osel[10] = 5'd0;
        settle();
        chk("R9 other inputs", 32'(per_in & ~8'h08), 32'(in_before & ~8'h08));
        chk("R9 other pin levels", 32'(pin_out & ~26'h400), 32'(out_before & ~26'h400));
        chk("R9 other pin enables", 32'(pin_oe & ~26'h400), 32'(oe_before & ~26'h400));
        chk("R9 changed input", 32'(per_in[3]), 32'(pin_in[1]));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_in_route();
        t_in_absent();
        t_in_fanout();
        t_out_route();
        t_out_release();
        t_out_fanout();
        t_comb_path();
        t_isolation();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule